// File: doc/BRIEF.md
# Configuration Memory Checksum Engine

This block keeps the integrity word of a small word-organised configuration memory correct. A one-cycle `start_i` pulse begins an operation, and `mode_i` selects the kind. A check operation reads every word from address 0 up to and including the checksum address and adds them into a 16-bit total. The operation passes only if that total equals the fixed signature 0xBABA. A fix operation adds only the words below the checksum address and then writes the signature minus that sum into the checksum address, so the whole image totals the signature afterwards.

The block talks to a memory protocol engine through two request ports. The read port takes one-cycle requests and answers each one with a completion strobe that can carry an error flag. The single-word write port works the same way. At most one read is in flight at any time. When the operation ends, `done_o` pulses, and `pass_o` and `sum_o` then hold the outcome until the next operation starts.

The sequencer has six states:
- IDLE waits for `start_i`.
- RD_ISSUE drives one read request.
- RD_WAIT waits for the read completion.
- WR_ISSUE drives the write request.
- WR_WAIT waits for the write completion.
- FINISH raises `done_o`.

The transitions are:
- start accepted: IDLE to RD_ISSUE.
- request sent: RD_ISSUE to RD_WAIT.
- next word: RD_WAIT to RD_ISSUE.
- sweep ended in a check operation: RD_WAIT to FINISH.
- sweep ended in a fix operation: RD_WAIT to WR_ISSUE.
- read failed: RD_WAIT to FINISH.
- write sent: WR_ISSUE to WR_WAIT.
- write answered: WR_WAIT to FINISH.
- report: FINISH to IDLE.

Top module: `nvm_sum_engine`

## Requirements
- R1: After reset `busy_o`, `done_o`, `pass_o`, `rd_req_o` and `wr_req_o` are 0 and `sum_o` is 0.
- R2: Words are added as 16-bit values and every carry out of bit 15 is dropped.
- R3: A check operation reads addresses 0 through CSUM_ADDR (default 63). `sum_o` reports the total, and `pass_o` is 1 exactly when the total equals 0xBABA.
- R4: A fix operation reads addresses 0 through CSUM_ADDR-1 and issues one write to CSUM_ADDR with data 0xBABA minus their sum. `sum_o` reports that written value, and `pass_o` is 1 when the write completes without error.
- R5: Reads go out in ascending address order starting at 0. Each request lasts one cycle, and no new request is issued until the previous one has completed.
- R6: A read completion with `rd_err_i` high ends the operation with `pass_o` = 0, and no write is issued.
- R7: A write completion with `wr_err_i` high ends the operation with `pass_o` = 0.
- R8: `busy_o` is high from the cycle after `start_i` is accepted until the operation ends. `done_o` is a single-cycle pulse, and `busy_o` is low in the cycle after it.
- R9: `start_i` is ignored while `busy_o` is high. The mode of the running operation is kept, and no second operation follows.
- R10: `mode_i` = 0 selects check and `mode_i` = 1 selects fix. The mode is sampled in the cycle `start_i` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle operation start |
| mode_i | input | 1 | 0 = check, 1 = fix |
| rd_req_o | output | 1 | Read request strobe |
| rd_addr_o | output | AW | Read word address |
| rd_valid_i | input | 1 | Read completion strobe |
| rd_err_i | input | 1 | Read failed, qualified by rd_valid_i |
| rd_data_i | input | DW | Read word |
| wr_req_o | output | 1 | Write request strobe |
| wr_addr_o | output | AW | Write word address (checksum address) |
| wr_data_o | output | DW | Write word |
| wr_done_i | input | 1 | Write completion strobe |
| wr_err_i | input | 1 | Write failed, qualified by wr_done_i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished, one cycle |
| pass_o | output | 1 | Outcome of the last operation |
| sum_o | output | DW | Total (check) or written value (fix) |

## Verification
A wrong sequencer state or address counter shows up at the read port almost at once. It appears as a skipped or repeated address, as a second request while one is outstanding, or as the wrong number of reads before `done_o`. A corrupted accumulator stays hidden until the operation ends. It then shows as a wrong `sum_o`, a wrong `pass_o`, or a wrong word written back into the memory model, so a single-word corruption or an injected failure is caught at the end of every operation. A lost mode bit shows at the write port, either as a write that should not happen or as a missing one.

// File: rtl/nvm_sum_pkg.sv
package nvm_sum_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_WR_ISSUE,
        ST_WR_WAIT,
        ST_FINISH
    } nsum_state_t;

    typedef enum logic {
        MODE_CHECK = 1'b0,
        MODE_FIX   = 1'b1
    } nsum_mode_t;

endpackage

// File: rtl/nvm_sum_acc.sv
module nvm_sum_acc #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          add_i,
    input  logic [DW-1:0] word_i,
    output logic [DW-1:0] sum_q_o,
    output logic [DW-1:0] sum_next_o
);

    logic [DW-1:0] sum_q;

    // Modular add: the carry out of the top bit is dropped (R2)
    assign sum_next_o = sum_q + word_i;
    assign sum_q_o    = sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (clear_i) begin
            sum_q <= '0;
        end else if (add_i) begin
            sum_q <= sum_next_o;
        end
    end

endmodule

// File: rtl/nvm_addr_step.sv
module nvm_addr_step #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          inc_i,
    input  logic [AW-1:0] last_i,
    output logic [AW-1:0] addr_o,
    output logic          at_last_o
);

    logic [AW-1:0] addr_q;

    assign addr_o    = addr_q;
    assign at_last_o = (addr_q == last_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clear_i) begin
            addr_q <= '0;
        end else if (inc_i) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    // R5: the counter never runs past the last address of the sweep
    a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> (addr_q != last_i));

endmodule

// File: rtl/nvm_sum_engine.sv
module nvm_sum_engine
    import nvm_sum_pkg::*;
#(
    parameter int             DW        = 16,
    parameter int             CSUM_ADDR = 63,
    parameter logic [DW-1:0]  SIGNATURE = 16'hBABA,
    localparam int            AW        = (CSUM_ADDR < 2) ? 1 : $clog2(CSUM_ADDR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic          rd_err_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          wr_req_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    input  logic          wr_done_i,
    input  logic          wr_err_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          pass_o,
    output logic [DW-1:0] sum_o
);

    localparam logic [AW-1:0] ADDR_CSUM = AW'(CSUM_ADDR);
    localparam logic [AW-1:0] ADDR_PRE  = AW'(CSUM_ADDR - 1);

    nsum_state_t   state_q, state_d;
    nsum_mode_t    mode_q;
    logic          pass_q;
    logic [DW-1:0] result_q;

    logic          accept;
    logic          rd_ok;
    logic [DW-1:0] sum_q, sum_next;
    logic [AW-1:0] addr, last_addr;
    logic          at_last;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign rd_ok     = (state_q == ST_RD_WAIT) && rd_valid_i && !rd_err_i;
    assign last_addr = (mode_q == MODE_FIX) ? ADDR_PRE : ADDR_CSUM;

    nvm_sum_acc #(.DW(DW)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (accept),
        .add_i      (rd_ok),
        .word_i     (rd_data_i),
        .sum_q_o    (sum_q),
        .sum_next_o (sum_next)
    );

    nvm_addr_step #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .inc_i     (rd_ok && !at_last),
        .last_i    (last_addr),
        .addr_o    (addr),
        .at_last_o (at_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_RD_ISSUE;
            ST_RD_ISSUE: state_d = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (rd_valid_i) begin
                    if (rd_err_i)                 state_d = ST_FINISH;
                    else if (!at_last)            state_d = ST_RD_ISSUE;
                    else if (mode_q == MODE_FIX)  state_d = ST_WR_ISSUE;
                    else                          state_d = ST_FINISH;
                end
            end
            ST_WR_ISSUE: state_d = ST_WR_WAIT;
            ST_WR_WAIT:  if (wr_done_i) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Operation context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_CHECK;
            pass_q   <= 1'b0;
            result_q <= '0;
        end else if (accept) begin
            mode_q   <= nsum_mode_t'(mode_i);
            pass_q   <= 1'b0;
            result_q <= '0;
        end else if (state_q == ST_RD_WAIT && rd_valid_i) begin
            if (rd_err_i) begin
                pass_q <= 1'b0;
            end else if (at_last) begin
                if (mode_q == MODE_FIX) begin
                    result_q <= SIGNATURE - sum_next;
                end else begin
                    result_q <= sum_next;
                    pass_q   <= (sum_next == SIGNATURE);
                end
            end
        end else if (state_q == ST_WR_WAIT && wr_done_i) begin
            pass_q <= !wr_err_i;
        end
    end

    // Outputs
    always_comb begin
        rd_req_o  = (state_q == ST_RD_ISSUE);
        rd_addr_o = addr;
        wr_req_o  = (state_q == ST_WR_ISSUE);
        wr_addr_o = ADDR_CSUM;
        wr_data_o = result_q;
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_FINISH);
        pass_o    = pass_q;
        sum_o     = result_q;
    end

    // R5: a read request lasts exactly one cycle
    a_r5_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    // R8: done is a one-cycle pulse followed by idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R4: only fix operations write
    a_r4_write_only_fix: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (mode_q == MODE_FIX));

    // R9: the mode holds for the whole operation
    a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mode_q));

    // R6: a failed read never leads to a write
    a_r6_no_write_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_WAIT && rd_valid_i && rd_err_i) |=> (state_q == ST_FINISH && !pass_o));

endmodule

// File: tb/test_nvm_sum_engine.sv
module test_nvm_sum_engine;

    localparam int DW = 16;
    localparam int CSUM = 63;
    localparam int AW = 6;
    localparam logic [15:0] SIG = 16'hBABA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_valid_i = 1'b0;
    logic          rd_err_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          wr_req_o;
    logic [AW-1:0] wr_addr_o;
    logic [DW-1:0] wr_data_o;
    logic          wr_done_i = 1'b0;
    logic          wr_err_i = 1'b0;
    logic          busy_o, done_o, pass_o;
    logic [DW-1:0] sum_o;

    nvm_sum_engine #(.DW(DW), .CSUM_ADDR(CSUM), .SIGNATURE(SIG)) i_nvm_sum_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
        .rd_err_i(rd_err_i), .rd_data_i(rd_data_i),
        .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_done_i(wr_done_i), .wr_err_i(wr_err_i),
        .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .sum_o(sum_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    logic [15:0] mem [0:63];
    int  n_tests = 0, n_fail = 0;
    int  n_reads, n_writes, rd_expect, rd_err_addr = -1;
    bit  wr_fail = 0, order_bad, overlap_bad;
    logic [AW-1:0] last_wr_addr;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] f_sum(input int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + mem[i];
        return s;
    endfunction

    // Read responder: one to three cycles of latency
    initial begin
        forever begin
            @(negedge clk);
            rd_valid_i = 1'b0;
            rd_err_i   = 1'b0;
            if (rd_req_o) begin
                automatic logic [AW-1:0] a = rd_addr_o;
                automatic int lat = 1 + int'($urandom % 3);
                if (int'(a) != rd_expect) order_bad = 1;
                rd_expect++;
                n_reads++;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    if (rd_req_o) overlap_bad = 1;
                end
                rd_valid_i = 1'b1;
                rd_data_i  = mem[a];
                rd_err_i   = (int'(a) == rd_err_addr);
            end
        end
    end

    // Write responder
    initial begin
        forever begin
            @(negedge clk);
            wr_done_i = 1'b0;
            wr_err_i  = 1'b0;
            if (wr_req_o) begin
                automatic logic [AW-1:0] a = wr_addr_o;
                automatic logic [15:0]   d = wr_data_o;
                automatic int lat = 1 + int'($urandom % 3);
                n_writes++;
                last_wr_addr = a;
                for (int k = 0; k < lat; k++) @(negedge clk);
                wr_done_i = 1'b1;
                wr_err_i  = wr_fail;
                if (!wr_fail) mem[a] = d;
            end
        end
    end

    // Run one operation and check its outcome
    task automatic run_op(input bit mode, input bit exp_pass, input logic [15:0] exp_sum,
                          input int exp_reads, input int exp_writes, input bit poke,
                          input string req);
        int cyc;
        n_reads = 0; n_writes = 0; rd_expect = 0; order_bad = 0; overlap_bad = 0;
        @(negedge clk);
        start_i = 1'b1; mode_i = mode;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
        if (poke) begin
            repeat (2) @(negedge clk);
            start_i = 1'b1; mode_i = ~mode;
            @(negedge clk);
            start_i = 1'b0; mode_i = mode;
        end
        cyc = 0;
        while (!done_o && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        check(done_o == 1'b1, req, "done seen", done_o, 1);
        check(pass_o == exp_pass, req, "pass", pass_o, exp_pass);
        if (exp_pass || mode == 1'b0)
            check(sum_o == exp_sum, req, "sum", sum_o, exp_sum);
        check(n_reads == exp_reads, req, "read count", n_reads, exp_reads);
        check(n_writes == exp_writes, req, "write count", n_writes, exp_writes);
        check(!order_bad, "R5", "ascending addresses", order_bad, 0);
        check(!overlap_bad, "R5", "one outstanding read", overlap_bad, 0);
        @(negedge clk);
        check(done_o == 1'b0 && busy_o == 1'b0, "R8", "done one cycle then idle",
              {done_o, busy_o}, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy_o && !done_o && !pass_o && !rd_req_o && !wr_req_o && sum_o == 0,
              "R1", "reset outputs", {busy_o, done_o, pass_o, rd_req_o, wr_req_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R10: fix operation writes the complement
        begin
            automatic logic [15:0] e = SIG - f_sum(CSUM);
            run_op(1'b1, 1'b1, e, CSUM, 1, 1'b0, "R4");
            check(mem[CSUM] == e, "R4", "checksum word written", mem[CSUM], e);
            check(last_wr_addr == 6'(CSUM), "R4", "write address", last_wr_addr, CSUM);
        end
        // R3: check after fix passes
        run_op(1'b0, 1'b1, SIG, CSUM + 1, 0, 1'b0, "R3");
        // R3: corrupted word fails
        mem[17] = mem[17] ^ 16'h0040;
        run_op(1'b0, 1'b0, f_sum(CSUM + 1), CSUM + 1, 0, 1'b0, "R3");

        // R2: all-ones image, heavy carry wrap
        for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
        run_op(1'b1, 1'b1, SIG - 16'hFFC1, CSUM, 1, 1'b0, "R2");
        run_op(1'b0, 1'b1, SIG, CSUM + 1, 0, 1'b0, "R2");

        // R6: read error aborts, no write
        rd_err_addr = 10;
        run_op(1'b0, 1'b0, 16'h0, 11, 0, 1'b0, "R6");
        begin
            automatic logic [15:0] keep = mem[CSUM];
            run_op(1'b1, 1'b0, 16'h0, 11, 0, 1'b0, "R6");
            check(mem[CSUM] == keep, "R6", "checksum word untouched", mem[CSUM], keep);
        end
        rd_err_addr = -1;

        // R7: write error reports fail
        mem[3] = 16'h1234;
        wr_fail = 1;
        begin
            automatic logic [15:0] keep = mem[CSUM];
            run_op(1'b1, 1'b0, 16'h0, CSUM, 1, 1'b0, "R7");
            check(mem[CSUM] == keep, "R7", "memory unchanged", mem[CSUM], keep);
        end
        wr_fail = 0;

        // R9: start during a check operation is ignored
        run_op(1'b0, 1'b0, f_sum(CSUM + 1), CSUM + 1, 0, 1'b1, "R9");
        begin
            automatic bit extra = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (busy_o || done_o || rd_req_o) extra = 1;
            end
            check(!extra, "R9", "no second operation", extra, 0);
        end

        // R3 / R4 / R10: random images and modes
        for (int it = 0; it < 6; it++) begin
            automatic bit m = 1'($urandom);
            for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
            if (m) run_op(1'b1, 1'b1, SIG - f_sum(CSUM), CSUM, 1, 1'b0, "R10");
            else   run_op(1'b0, f_sum(CSUM + 1) == SIG, f_sum(CSUM + 1), CSUM + 1, 0, 1'b0, "R10");
            run_op(1'b0, m ? 1'b1 : (f_sum(CSUM + 1) == SIG), f_sum(CSUM + 1), CSUM + 1, 0, 1'b0, "R3");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule